// File: doc/BRIEF.md
# Cache Line Atomic Lock Tracker

This block sits beside the tag array of a set-associative cache. It records which execution context has reserved each line for an atomic read-modify-write pair. When an atomic read completes on a line that is present, the block stores the requester's context ID as that line's owner. When the matching atomic write completes, the block reports whether the same context still owns the line. A successful write releases the reservation. A failed write leaves the reservation as it was.

Several events silently drop a reservation: installing a new line into a way, evicting a line, or changing a line's access permission. The tag lookup is modelled by a small internal tag array. The caller drives one operation per cycle with a set index, a tag, a way and a context ID, and each result appears one cycle later. Data storage, coherence traffic and the choice of victim way are left to the surrounding cache.

Top module: `lockTracker`

## Requirements
- R1: After reset every way of every set is invalid and unlocked, and the outputs `wrDone`, `wrOk` and `missErr` are low.
- R2: An atomic read (`opKind` = 4) that hits a valid line with a matching tag makes `opCtx` the owner of that way. This replaces any earlier owner.
- R3: An atomic write (`opKind` = 5) raises `wrDone` for one cycle, one cycle after it is presented. `wrOk` is high in that cycle only if the hit way is locked with an owner equal to `opCtx`.
- R4: A successful atomic write unlocks the way, so a repeated write by the same context fails.
- R5: A failed atomic write leaves the owner of the line unchanged.
- R6: An allocate (`opKind` = 1) writes `opTag` into way `opWay` of set `opSet`, marks it valid and unlocks it.
- R7: A deallocate (`opKind` = 2) that hits invalidates and unlocks that way. A deallocate that misses changes nothing.
- R8: A permission change (`opKind` = 3) that hits unlocks the line and leaves it valid. A permission change that misses changes nothing.
- R9: An atomic read or write that misses raises `missErr` for one cycle, one cycle later, and changes no state. A missing write also reports `wrDone` high with `wrOk` low.
- R10: All 16 values of the 4-bit context ID can own a line. The unlocked state is held separately from the owner value.
- R11: `opKind` values 0, 6 and 7, and any cycle with `opValid` low, change no state and raise no output. `missErr` and `wrDone` only follow atomic operations. A hit searches the ways from way 0 upward and takes the first one whose tag matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 3 | Operation code (1 alloc, 2 dealloc, 3 permission change, 4 atomic read, 5 atomic write) |
| opSet | input | SET_W | Set index |
| opTag | input | TAG_W | Line tag |
| opWay | input | WAY_W | Target way, used only by allocate |
| opCtx | input | CTX_W | Requesting context ID |
| wrDone | output | 1 | Atomic write result is valid |
| wrOk | output | 1 | Atomic write succeeded |
| missErr | output | 1 | Atomic operation missed in the tag array |

## Verification
The bench builds the tracker with 2 sets, 2 ways and 3-bit tags, and keeps the 4-bit context width. This small array lets every pair of reading and writing contexts be tried on every way. Each pair is run through a read, a mismatched write, the owner's write and a repeated write. With only 8 tags and 2 ways, a random stream of allocations, evictions and permission changes keeps hitting occupied ways, duplicate tags and misses. Those cases exercise lock clearing, first-match way priority and error reporting against an arithmetic model of the array.

// File: rtl/lockTrkPkg.sv
package lockTrkPkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_DEALLOC = 3'd2,
    OP_PERM    = 3'd3,
    OP_ATOM_RD = 3'd4,
    OP_ATOM_WR = 3'd5
  } opKindE;

  // Strobes from control to the tag/lock datapath.
  typedef struct packed {
    logic tagWrite;   // install opTag into the target way
    logic invalidate; // clear line valid of the target way
    logic lockSet;    // record opCtx as owner of the target way
    logic lockClear;  // drop the reservation of the target way
    logic useOpWay;   // target way is opWay instead of the hit way
  } strobeT;
endpackage

// File: rtl/lockTrkDatapath.sv
module lockTrkDatapath
  import lockTrkPkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int CTX_W = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] opSet,
  input  logic [TAG_W-1:0] opTag,
  input  logic [WAY_W-1:0] opWay,
  input  logic [CTX_W-1:0] opCtx,
  input  strobeT           strobe,
  output logic             hit,
  output logic             ownerMatch
);
  logic [WAYS-1:0]  lineValid [SETS];
  logic [WAYS-1:0]  lockValid [SETS];
  logic [TAG_W-1:0] tagMem    [SETS][WAYS];
  logic [CTX_W-1:0] lockOwner [SETS][WAYS];

  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] tgtWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = lineValid[opSet][w] && (tagMem[opSet][w] == opTag);
  end

  // lowest matching way wins
  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign hit        = |hitVec;
  assign ownerMatch = lockValid[opSet][hitWay] && (lockOwner[opSet][hitWay] == opCtx);
  assign tgtWay     = strobe.useOpWay ? opWay : hitWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lineValid[s] <= '0;
        lockValid[s] <= '0;
      end
    end else begin
      if (strobe.tagWrite)   lineValid[opSet][tgtWay] <= 1'b1;
      if (strobe.invalidate) lineValid[opSet][tgtWay] <= 1'b0;
      if (strobe.lockSet)    lockValid[opSet][tgtWay] <= 1'b1;
      if (strobe.lockClear)  lockValid[opSet][tgtWay] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.tagWrite) tagMem[opSet][tgtWay]    <= opTag;
    if (strobe.lockSet)  lockOwner[opSet][tgtWay] <= opCtx;
  end
endmodule

// File: rtl/lockTrkControl.sv
module lockTrkControl
  import lockTrkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       hit,
  input  logic       ownerMatch,
  output strobeT     strobe,
  output logic       wrDone,
  output logic       wrOk,
  output logic       missErr
);
  opKindE kind;
  logic   isRd, isWr;
  logic   doneNxt, okNxt, errNxt;

  assign kind = opKindE'(opKind);
  assign isRd = opValid && (kind == OP_ATOM_RD);
  assign isWr = opValid && (kind == OP_ATOM_WR);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (kind)
        OP_ALLOC: begin
          strobe.tagWrite  = 1'b1;
          strobe.lockClear = 1'b1;
          strobe.useOpWay  = 1'b1;
        end
        OP_DEALLOC: begin
          strobe.invalidate = hit;
          strobe.lockClear  = hit;
        end
        OP_PERM:    strobe.lockClear = hit;
        OP_ATOM_RD: strobe.lockSet   = hit;
        OP_ATOM_WR: strobe.lockClear = hit && ownerMatch;
        default: ;
      endcase
    end
  end

  assign doneNxt = isWr;
  assign okNxt   = isWr && hit && ownerMatch;
  assign errNxt  = (isRd || isWr) && !hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrDone  <= 1'b0;
      wrOk    <= 1'b0;
      missErr <= 1'b0;
    end else begin
      wrDone  <= doneNxt;
      wrOk    <= okNxt;
      missErr <= errNxt;
    end
  end
endmodule

// File: rtl/lockTracker.sv
module lockTracker
  import lockTrkPkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int CTX_W = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opKind,
  input  logic [SET_W-1:0] opSet,
  input  logic [TAG_W-1:0] opTag,
  input  logic [WAY_W-1:0] opWay,
  input  logic [CTX_W-1:0] opCtx,
  output logic             wrDone,
  output logic             wrOk,
  output logic             missErr
);
  strobeT strobe;
  logic   hit, ownerMatch;

  lockTrkDatapath #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .opSet(opSet), .opTag(opTag), .opWay(opWay),
    .opCtx(opCtx), .strobe(strobe), .hit(hit), .ownerMatch(ownerMatch)
  );

  lockTrkControl ctl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .hit(hit),
    .ownerMatch(ownerMatch), .strobe(strobe), .wrDone(wrDone), .wrOk(wrOk),
    .missErr(missErr)
  );
endmodule

// File: rtl/lockTrkChecker.sv
module lockTrkChecker (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [2:0] opKind,
  input logic       wrDone,
  input logic       wrOk,
  input logic       missErr
);
  // R3: a write result follows exactly one cycle after each atomic write
  p_done_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrDone == $past(opValid && opKind == 3'd5));

  // R9: a miss flag only follows an atomic request
  p_err_after_atomic_r9: assert property (@(posedge clk) disable iff (!rstN)
    missErr |-> $past(opValid && (opKind == 3'd4 || opKind == 3'd5)));

  // R9: success is never reported together with a miss, nor outside a result
  p_ok_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrOk |-> (wrDone && !missErr));

  // R11: ops that are not atomic raise nothing in the next cycle
  p_quiet_non_atomic_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && (opKind == 3'd4 || opKind == 3'd5)) |=> (!missErr && !wrDone));
endmodule

bind lockTracker lockTrkChecker chk_i (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
  .wrDone(wrDone), .wrOk(wrOk), .missErr(missErr)
);

// File: tb/lockTracker_tb_top.sv
module lockTracker_tb_top;
  localparam int SETS = 2, WAYS = 2, TAG_W = 3, CTX_W = 4;
  localparam int SET_W = 1, WAY_W = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opKind = '0;
  logic [SET_W-1:0] opSet = '0;
  logic [TAG_W-1:0] opTag = '0;
  logic [WAY_W-1:0] opWay = '0;
  logic [CTX_W-1:0] opCtx = '0;
  logic wrDone, wrOk, missErr;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // model of the array
  bit             mValid [SETS][WAYS];
  bit [TAG_W-1:0] mTag   [SETS][WAYS];
  bit             mLockV [SETS][WAYS];
  bit [CTX_W-1:0] mOwner [SETS][WAYS];

  always #10 clk = ~clk; // 50 MHz

  lockTracker #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opSet(opSet),
    .opTag(opTag), .opWay(opWay), .opCtx(opCtx), .wrDone(wrDone), .wrOk(wrOk),
    .missErr(missErr)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {wrDone,wrOk,missErr} actual %b expected %b", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic doOp(input int kind, input int s, input int tag, input int way,
                      input int ctx, input string req);
    bit hit = 0; int hw = 0; bit own; bit eDone, eOk, eErr;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mValid[s][w] && mTag[s][w] == tag[TAG_W-1:0]) begin hit = 1; hw = w; end
    own   = hit && mLockV[s][hw] && mOwner[s][hw] == ctx[CTX_W-1:0];
    eDone = (kind == 5);
    eOk   = eDone && own;
    eErr  = (kind == 4 || kind == 5) && !hit;
    opValid = 1'b1; opKind = kind[2:0]; opSet = s[SET_W-1:0];
    opTag = tag[TAG_W-1:0]; opWay = way[WAY_W-1:0]; opCtx = ctx[CTX_W-1:0];
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    check(req, {wrDone, wrOk, missErr}, {eDone, eOk, eErr});
    case (kind)
      1: begin mValid[s][way] = 1; mTag[s][way] = tag[TAG_W-1:0]; mLockV[s][way] = 0; end
      2: if (hit) begin mValid[s][hw] = 0; mLockV[s][hw] = 0; end
      3: if (hit) mLockV[s][hw] = 0;
      4: if (hit) begin mLockV[s][hw] = 1; mOwner[s][hw] = ctx[CTX_W-1:0]; end
      5: if (own) mLockV[s][hw] = 0;
      default: ;
    endcase
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mValid[s][w] = 0; mLockV[s][w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset outputs", {wrDone, wrOk, missErr}, 3'b000);
    // R1: empty array, every atomic op misses
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 8; t++) begin
        doOp(4, s, t, 0, t, "R1/R9 read miss after reset");
        doOp(5, s, t, 0, t, "R1/R9 write miss after reset");
      end
    // R2 R3 R4 R5 R10: every reader/writer context pair on every way
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        for (int c = 0; c < 16; c++)
          for (int d = 0; d < 16; d++) begin
            doOp(1, s, 2 + w, w, 0, "R6 alloc");
            doOp(4, s, 2 + w, 0, c, "R2 atomic read");
            doOp(5, s, 2 + w, 0, d, "R3/R10 write by other ctx");
            doOp(5, s, 2 + w, 0, c, "R5 owner write after other");
            doOp(5, s, 2 + w, 0, c, "R4 repeat write");
          end
    // R2: later reader replaces owner
    doOp(1, 0, 5, 0, 0, "R6 alloc");
    doOp(4, 0, 5, 0, 3, "R2 read ctx3");
    doOp(4, 0, 5, 0, 9, "R2 read ctx9");
    doOp(5, 0, 5, 0, 3, "R2 old owner fails");
    doOp(4, 0, 5, 0, 9, "R2 relock ctx9");
    doOp(5, 0, 5, 0, 9, "R2 new owner ok");
    // R6: reallocating a locked way drops the lock
    doOp(4, 0, 5, 0, 7, "R2 lock");
    doOp(1, 0, 5, 0, 0, "R6 realloc same way");
    doOp(5, 0, 5, 0, 7, "R6 write after realloc fails");
    // R8: permission change unlocks, line stays valid
    doOp(4, 0, 5, 0, 4, "R2 lock");
    doOp(3, 0, 5, 0, 0, "R8 perm change");
    doOp(5, 0, 5, 0, 4, "R8 write after perm fails");
    doOp(4, 0, 5, 0, 4, "R8 line still valid");
    doOp(3, 0, 6, 0, 0, "R8 perm miss");
    doOp(5, 0, 5, 0, 4, "R8 lock kept after perm miss");
    // R7: dealloc miss keeps lock, hit invalidates
    doOp(4, 0, 5, 0, 2, "R2 lock");
    doOp(2, 0, 6, 0, 0, "R7 dealloc miss");
    doOp(5, 0, 5, 0, 2, "R7 lock kept after dealloc miss");
    doOp(4, 0, 5, 0, 2, "R2 lock");
    doOp(2, 0, 5, 0, 0, "R7 dealloc hit");
    doOp(5, 0, 5, 0, 2, "R7/R9 write after dealloc misses");
    // R11: duplicate tags pick way 0, and ignored codes
    doOp(1, 1, 4, 0, 0, "R11 alloc w0");
    doOp(1, 1, 4, 1, 0, "R11 alloc w1 same tag");
    doOp(4, 1, 4, 0, 8, "R11 lock lowest way");
    doOp(6, 1, 4, 0, 8, "R11 code 6 ignored");
    doOp(7, 1, 4, 0, 8, "R11 code 7 ignored");
    doOp(0, 1, 4, 0, 8, "R11 code 0 ignored");
    doOp(5, 1, 4, 0, 8, "R11 lock survives ignored codes");
    // random mix against the model
    for (int i = 0; i < 4000; i++)
      doOp($urandom_range(0, 7), $urandom_range(0, SETS - 1), $urandom_range(0, 7),
           $urandom_range(0, WAYS - 1), $urandom_range(0, 15), "R2..R11 random mix");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule